// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset into a 20-bit physical address for a processor that sees a 1 MB memory space through four 16-bit segment registers. The registers are code, data, stack and extra. Each request carries an access kind, and the kind selects a default segment register. A request may also name an override segment, which replaces the default for the kinds that permit it. The chosen segment value, shifted left by four bits, is added to the zero-extended offset. Any carry above bit 19 is dropped.

The block also classifies each address into one of four memory regions, using the top hex digit of the address. A far-pointer access kind takes a segment value from the request itself. It uses that value for the current address and also loads it into the data segment register. A separate write port lets the surrounding logic load any segment register. All results appear on registered outputs one cycle after the request.

Top module: `seg_addr_unit`

## Requirements
- R1: After reset the code segment register holds 0xFFFF, the data, stack and extra segment registers hold 0x0000, and out_valid is low.
- R2: out_addr equals (segment value × 16 + offset) modulo 2^20, so a sum at or above 0x100000 wraps to the bottom of the space.
- R3: Access kind 0 (instruction fetch) always uses the code segment, and a segment override has no effect on it.
- R4: Access kind 1 (load/store) uses the data segment by default, and kind 2 (push/pop) uses the stack segment by default.
- R5: Access kind 3 (block-move source) uses the data segment by default. Kind 4 (block-move destination) always uses the extra segment, and a segment override has no effect on it.
- R6: When req_ovr_en is high, kinds 1, 2 and 3 use the segment named by req_ovr_seg instead of their default. The codes are 0 code, 1 data, 2 stack and 3 extra.
- R7: A write on the register port (wr_sel uses the same codes as R6) takes effect from the next cycle. A request in the same cycle as the write still sees the old value.
- R8: Access kind 5 (far pointer) uses req_far_seg as the segment for its own address and loads req_far_seg into the data segment register. This load wins over a write-port write to the data segment in the same cycle, and a segment override has no effect on kind 5.
- R9: out_region is 0 when address bits 19:16 are 0x0 to 0x9, 1 for 0xA to 0xB, 2 for 0xC to 0xD, and 3 for 0xE to 0xF.
- R10: out_valid, out_addr and out_region update one cycle after a request. If there is no request, or the request uses kind 6 or 7, out_valid is low in the next cycle and out_addr and out_region keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Address request this cycle |
| req_kind | input | 3 | Access kind code |
| req_offset | input | 16 | Offset within the segment |
| req_ovr_en | input | 1 | Segment override enable |
| req_ovr_seg | input | 2 | Override segment code |
| req_far_seg | input | 16 | Segment half of a far pointer (kind 5) |
| wr_en | input | 1 | Segment register write enable |
| wr_sel | input | 2 | Segment register to write |
| wr_data | input | 16 | Value to write |
| out_valid | output | 1 | Result valid |
| out_addr | output | 20 | Physical address |
| out_region | output | 2 | Memory region code |

## Verification
A table drives every access kind, with and without an override. The four segment registers are loaded with distinct values, so a wrong segment choice always shows up as a different address. Offsets near 0xFFFF and a code segment of 0xFFFF test the carry into the top nibble and the wrap past 1 MB. Addresses at 0x9FFFF, 0xA0000, 0xCxxxx and 0xFxxxx separate the region boundaries. Directed cycles pair a register write with a request in the same cycle, and a far-pointer load with a competing write, to check which value each observer sees.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

    typedef enum logic [1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_id_e;

    typedef enum logic [2:0] {
        ACC_FETCH = 3'd0,
        ACC_DATA  = 3'd1,
        ACC_STACK = 3'd2,
        ACC_MSRC  = 3'd3,
        ACC_MDST  = 3'd4,
        ACC_FAR   = 3'd5
    } acc_kind_e;

    typedef enum logic [1:0] {
        RGN_RAM      = 2'd0,
        RGN_VIDEO    = 2'd1,
        RGN_CARD_ROM = 2'd2,
        RGN_SYS_ROM  = 2'd3
    } region_e;

    localparam int NUM_SEGS   = 4;
    localparam int SEL_W      = $clog2(NUM_SEGS);
    localparam int KIND_W     = 3;
    localparam int NIBBLE_W   = 4;

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
    import seg_addr_pkg::*;
#(
    parameter int SEG_W = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [SEL_W-1:0]                 wr_sel,
    input  logic [SEG_W-1:0]                 wr_data,
    input  logic                             far_en,
    input  logic [SEG_W-1:0]                 far_data,
    output logic [NUM_SEGS-1:0][SEG_W-1:0]   seg_o
);

    typedef logic [NUM_SEGS-1:0][SEG_W-1:0] bank_t;

    function automatic bank_t reset_image();
        bank_t img;
        for (int i = 0; i < NUM_SEGS; i++) begin
            img[i] = (i == int'(SEG_CODE)) ? {SEG_W{1'b1}} : {SEG_W{1'b0}};
        end
        return img;
    endfunction

    localparam bank_t RST_BANK = reset_image();

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            bank_d[wr_sel] = wr_data;
        end
        // a far-pointer load has priority over the write port
        if (far_en) begin
            bank_d[SEG_DATA] = far_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= RST_BANK;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign seg_o = bank_q;

endmodule

// File: rtl/seg_select.sv
module seg_select
    import seg_addr_pkg::*;
(
    input  logic [KIND_W-1:0] kind,
    input  logic              ovr_en,
    input  logic [SEL_W-1:0]  ovr_seg,
    output logic [SEL_W-1:0]  sel,
    output logic              legal,
    output logic              use_far
);

    always_comb begin
        sel     = SEG_DATA;
        legal   = 1'b1;
        use_far = 1'b0;
        unique case (kind)
            ACC_FETCH: sel = SEG_CODE;
            ACC_DATA:  sel = ovr_en ? ovr_seg : SEG_DATA;
            ACC_STACK: sel = ovr_en ? ovr_seg : SEG_STACK;
            ACC_MSRC:  sel = ovr_en ? ovr_seg : SEG_DATA;
            ACC_MDST:  sel = SEG_EXTRA;
            ACC_FAR: begin
                sel     = SEG_DATA;
                use_far = 1'b1;
            end
            default:   legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/phys_calc.sv
module phys_calc
    import seg_addr_pkg::*;
#(
    parameter int SEG_W  = 16,
    parameter int OFS_W  = 16,
    parameter int ADDR_W = 20
) (
    input  logic [SEG_W-1:0]  base,
    input  logic [OFS_W-1:0]  offset,
    output logic [ADDR_W-1:0] addr,
    output region_e           region
);

    localparam int SHIFT   = ADDR_W - SEG_W;
    localparam int OFS_PAD = ADDR_W - OFS_W;

    logic [ADDR_W-1:0]   base_sh;
    logic [ADDR_W-1:0]   ofs_ext;
    logic [NIBBLE_W-1:0] top;

    always_comb begin
        base_sh = {base, {SHIFT{1'b0}}};
        ofs_ext = {{OFS_PAD{1'b0}}, offset};
        addr    = base_sh + ofs_ext;   // carry past the top bit is dropped
        top     = addr[ADDR_W-1 -: NIBBLE_W];
        if (top < 4'hA) begin
            region = RGN_RAM;
        end else if (top < 4'hC) begin
            region = RGN_VIDEO;
        end else if (top < 4'hE) begin
            region = RGN_CARD_ROM;
        end else begin
            region = RGN_SYS_ROM;
        end
    end

endmodule

// File: rtl/seg_addr_unit.sv
module seg_addr_unit
    import seg_addr_pkg::*;
#(
    parameter int SEG_W  = 16,
    parameter int OFS_W  = 16,
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [OFS_W-1:0]  req_offset,
    input  logic              req_ovr_en,
    input  logic [1:0]        req_ovr_seg,
    input  logic [SEG_W-1:0]  req_far_seg,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [SEG_W-1:0]  wr_data,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [1:0]        out_region
);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        region_e           region;
    } out_t;

    logic [NUM_SEGS-1:0][SEG_W-1:0] seg_bank;
    logic [SEL_W-1:0]               sel;
    logic                           legal;
    logic                           use_far;
    logic                           far_load;
    logic [SEG_W-1:0]               base;
    logic [ADDR_W-1:0]              addr_c;
    region_e                        region_c;
    out_t                           out_d, out_q;

    seg_select u_sel (
        .kind    (req_kind),
        .ovr_en  (req_ovr_en),
        .ovr_seg (req_ovr_seg),
        .sel     (sel),
        .legal   (legal),
        .use_far (use_far)
    );

    assign far_load = req_valid && use_far;

    seg_regfile #(.SEG_W(SEG_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .far_en   (far_load),
        .far_data (req_far_seg),
        .seg_o    (seg_bank)
    );

    assign base = use_far ? req_far_seg : seg_bank[sel];

    phys_calc #(.SEG_W(SEG_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W)) u_calc (
        .base   (base),
        .offset (req_offset),
        .addr   (addr_c),
        .region (region_c)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = req_valid && legal;
        if (req_valid && legal) begin
            out_d.addr   = addr_c;
            out_d.region = region_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid  = out_q.valid;
    assign out_addr   = out_q.addr;
    assign out_region = out_q.region;

endmodule

// File: rtl/seg_addr_unit_chk.sv
module seg_addr_unit_chk #(
    parameter int SEG_W  = 16,
    parameter int OFS_W  = 16,
    parameter int ADDR_W = 20
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic [2:0]            req_kind,
    input logic [OFS_W-1:0]      req_offset,
    input logic [SEG_W-1:0]      req_far_seg,
    input logic                  wr_en,
    input logic [1:0]            wr_sel,
    input logic [SEG_W-1:0]      wr_data,
    input logic                  out_valid,
    input logic [ADDR_W-1:0]     out_addr,
    input logic [1:0]            out_region,
    input logic [3:0][SEG_W-1:0] seg_bank
);

    localparam int SHIFT = ADDR_W - SEG_W;

    logic              legal_req;
    logic              far_req;
    logic [ADDR_W-1:0] fetch_expect;
    logic [3:0]        top;

    assign legal_req    = req_valid && (req_kind <= 3'd5);
    assign far_req      = req_valid && (req_kind == 3'd5);
    assign fetch_expect = {seg_bank[0], {SHIFT{1'b0}}} + {{(ADDR_W-OFS_W){1'b0}}, req_offset};
    assign top          = out_addr[ADDR_W-1 -: 4];

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (seg_bank[0] == {SEG_W{1'b1}}) && (seg_bank[1] == '0)
                         && (seg_bank[2] == '0) && (seg_bank[3] == '0) && !out_valid);

    assert_fetch_code_seg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 3'd0) |=> out_addr == $past(fetch_expect));

    assert_write_next_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(far_req && wr_sel == 2'd1)) |=> seg_bank[$past(wr_sel)] == $past(wr_data));

    assert_far_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        far_req |=> seg_bank[1] == $past(req_far_seg));

    assert_region_map_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_region == ((top < 4'hA) ? 2'd0 : (top < 4'hC) ? 2'd1 :
                                     (top < 4'hE) ? 2'd2 : 2'd3));

    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        legal_req |=> out_valid);

    assert_no_spurious_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !legal_req |=> !out_valid);

    assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !legal_req |=> $stable(out_addr) && $stable(out_region));

endmodule

bind seg_addr_unit seg_addr_unit_chk #(.SEG_W(SEG_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .req_offset  (req_offset),
    .req_far_seg (req_far_seg),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .out_valid   (out_valid),
    .out_addr    (out_addr),
    .out_region  (out_region),
    .seg_bank    (seg_bank)
);

// File: tb/seg_addr_unit_test.sv
module seg_addr_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [15:0] req_offset = '0;
    logic        req_ovr_en = 1'b0;
    logic [1:0]  req_ovr_seg = '0;
    logic [15:0] req_far_seg = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        out_valid;
    logic [19:0] out_addr;
    logic [1:0]  out_region;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    seg_addr_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_offset(req_offset), .req_ovr_en(req_ovr_en), .req_ovr_seg(req_ovr_seg),
        .req_far_seg(req_far_seg), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .out_valid(out_valid), .out_addr(out_addr), .out_region(out_region)
    );

    // {kind, ovr_en, ovr_seg, offset, expected addr, expected region}
    // segments while the table runs: code FFFF, data 1234, stack C000, extra A000
    localparam int NV = 14;
    localparam logic [43:0] VEC [NV] = '{
        {3'd0, 1'b0, 2'd0, 16'h0000, 20'hFFFF0, 2'd3},  // R3 fetch
        {3'd0, 1'b0, 2'd0, 16'h0010, 20'h00000, 2'd0},  // R2 wrap past 1 MB
        {3'd0, 1'b1, 2'd1, 16'h0005, 20'hFFFF5, 2'd3},  // R3 override ignored
        {3'd1, 1'b0, 2'd0, 16'h0100, 20'h12440, 2'd0},  // R4 data
        {3'd2, 1'b0, 2'd0, 16'hFFFE, 20'hCFFFE, 2'd2},  // R4 stack, R2 carry
        {3'd3, 1'b0, 2'd0, 16'h0002, 20'h12342, 2'd0},  // R5 move source
        {3'd4, 1'b0, 2'd0, 16'h0004, 20'hA0004, 2'd1},  // R5 move dest
        {3'd4, 1'b1, 2'd0, 16'h0004, 20'hA0004, 2'd1},  // R5 override ignored
        {3'd4, 1'b0, 2'd0, 16'h0000, 20'hA0000, 2'd1},  // R9 region edge
        {3'd1, 1'b1, 2'd3, 16'h1000, 20'hA1000, 2'd1},  // R6 data->extra
        {3'd2, 1'b1, 2'd0, 16'h0000, 20'hFFFF0, 2'd3},  // R6 stack->code
        {3'd3, 1'b1, 2'd2, 16'h0003, 20'hC0003, 2'd2},  // R6 source->stack
        {3'd1, 1'b1, 2'd2, 16'hFFFF, 20'hCFFFF, 2'd2},  // R6 data->stack
        {3'd2, 1'b1, 2'd1, 16'h0020, 20'h12360, 2'd0}   // R6 stack->data
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, sample at the following negedge
    task automatic cyc(input logic v, input logic [2:0] k, input logic oe, input logic [1:0] os,
                       input logic [15:0] off, input logic [15:0] far,
                       input logic we, input logic [1:0] ws, input logic [15:0] wd);
        @(negedge clk);
        req_valid = v; req_kind = k; req_ovr_en = oe; req_ovr_seg = os;
        req_offset = off; req_far_seg = far; wr_en = we; wr_sel = ws; wr_data = wd;
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0; req_ovr_en = 1'b0;
    endtask

    task automatic req(input logic [2:0] k, input logic [15:0] off);
        cyc(1'b1, k, 1'b0, 2'd0, off, 16'h0, 1'b0, 2'd0, 16'h0);
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        cyc(1'b0, 3'd0, 1'b0, 2'd0, 16'h0, 16'h0, 1'b1, s, d);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", 32'(out_valid), 32'd0);
        req(3'd0, 16'h0000); check("R1 code seg reset", 32'(out_addr), 32'hFFFF0);
        req(3'd1, 16'h0000); check("R1 data seg reset", 32'(out_addr), 32'h00000);
        req(3'd2, 16'h0000); check("R1 stack seg reset", 32'(out_addr), 32'h00000);
        req(3'd4, 16'h0000); check("R1 extra seg reset", 32'(out_addr), 32'h00000);

        wr(2'd1, 16'h1234);
        wr(2'd2, 16'hC000);
        wr(2'd3, 16'hA000);

        for (int i = 0; i < NV; i++) begin
            logic [2:0]  k;  logic oe; logic [1:0] os; logic [15:0] off;
            logic [19:0] ea; logic [1:0] er;
            {k, oe, os, off, ea, er} = VEC[i];
            cyc(1'b1, k, oe, os, off, 16'h0, 1'b0, 2'd0, 16'h0);
            check("R2 R3 R4 R5 R6 table addr", 32'(out_addr), 32'(ea));
            check("R9 table region", 32'(out_region), 32'(er));
            check("R10 table valid", 32'(out_valid), 32'd1);
        end

        // R9 boundary just below video RAM
        wr(2'd1, 16'h9000);
        req(3'd1, 16'hFFFF);
        check("R9 9FFFF addr", 32'(out_addr), 32'h9FFFF);
        check("R9 9FFFF region", 32'(out_region), 32'd0);

        // R7 write and request in the same cycle
        cyc(1'b1, 3'd1, 1'b0, 2'd0, 16'h0000, 16'h0, 1'b1, 2'd1, 16'h5000);
        check("R7 same-cycle sees old", 32'(out_addr), 32'h90000);
        req(3'd1, 16'h0000);
        check("R7 next cycle sees new", 32'(out_addr), 32'h50000);

        // R8 far pointer with override and a competing write to data seg
        cyc(1'b1, 3'd5, 1'b1, 2'd3, 16'h0010, 16'h3000, 1'b1, 2'd1, 16'h7777);
        check("R8 far addr", 32'(out_addr), 32'h30010);
        req(3'd1, 16'h0000);
        check("R8 data seg loaded by far", 32'(out_addr), 32'h30000);

        // R10 idle cycle and unused kind codes
        cyc(1'b0, 3'd1, 1'b0, 2'd0, 16'h1111, 16'h0, 1'b0, 2'd0, 16'h0);
        check("R10 idle valid low", 32'(out_valid), 32'd0);
        check("R10 idle addr held", 32'(out_addr), 32'h30000);
        cyc(1'b1, 3'd6, 1'b0, 2'd0, 16'h2222, 16'h0, 1'b0, 2'd0, 16'h0);
        check("R10 kind 6 no valid", 32'(out_valid), 32'd0);
        cyc(1'b1, 3'd7, 1'b0, 2'd0, 16'h2222, 16'h0, 1'b0, 2'd0, 16'h0);
        check("R10 kind 7 no valid", 32'(out_valid), 32'd0);
        check("R10 kind 7 addr held", 32'(out_addr), 32'h30000);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule